// File: doc/BRIEF.md
# Event-Triggered Delayed Transmit Timer

This block produces a transmit-start pulse a programmed time after a chosen frame-boundary event. Software sets up two byte-wide control registers. The first register holds a 2-bit start selector and the top six bits of a 14-bit delay length. The second register holds the lower eight bits of that length. When the selected event strobe arrives and the length is non-zero, the timer arms. It then counts down one step for every fixed time step, and the step is derived from the system clock by a prescaler. When the count expires, the block emits a single-cycle pulse.

The default step is 118 system-clock cycles, which is 590 ns at 200 MHz. This gives a usable range of 1 to 16383 steps. Writing a length of zero turns the timer off.

A register write, a write to the separate mode-control register (signalled by a clear strobe), or dropping the chip enable cancels a running count without a pulse. The clear strobe and a low enable also force both registers back to their defaults.

Top module: `dly_tx_timer`

## Requirements
- R1: After reset, and in every cycle in which `en` is low, the high register reads 0xC2 and the low register reads 0x00 (`rd_sel`=0 selects high, 1 selects low).
- R2: A write with `wr_en`=1 stores `wr_data` into the register chosen by `wr_sel` (0 = high, 1 = low). Readback returns the stored byte, never the running count, and a new value takes effect only at the next arming.
- R3: A cycle with `mode_clr`=1 reloads high to 0xC2 and low to 0x00, and this overrides a write in the same cycle.
- R4: High bits 7:6 select the arming event: 00 = `ev_txsof_begin`, 01 = `ev_txsof_end`, 10 = `ev_rxsof_begin`, 11 = `ev_rxsof_end`. Strobes of the other three events do not arm the timer.
- R5: The delay length is {high[5:0], low[7:0]}. When armed at clock edge k with length L, `busy` is high from edge k on. `tx_start` is high for exactly the one cycle after edge k + L*STEP_CYCLES, and `busy` falls at that same edge.
- R6: With a length of zero, no event arms the timer, so `busy` and `tx_start` stay low.
- R7: While `busy` is high, further event strobes are ignored and the pulse timing of the running count is unchanged.
- R8: A register write, a `mode_clr` strobe, or `en` low during a count ends the count at the next edge with `busy` low and no `tx_start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Chip enable; low forces defaults and cancels a count |
| mode_clr | input | 1 | Strobe marking a write to the mode-control register |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 high, 1 low |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Readback target: 0 high, 1 low |
| rd_data | output | 8 | Readback of the selected register |
| ev_txsof_begin | input | 1 | Strobe: start of transmitted start-of-frame |
| ev_txsof_end | input | 1 | Strobe: end of transmitted start-of-frame |
| ev_rxsof_begin | input | 1 | Strobe: start of received start-of-frame |
| ev_rxsof_end | input | 1 | Strobe: end of received start-of-frame |
| tx_start | output | 1 | One-cycle transmit-start pulse |
| busy | output | 1 | High while a count is running |

## Verification
The assertions take for granted that reset is synchronous and that every control input is stable around the rising edge. They also assume that a cancel cause (`wr_en`, `mode_clr`, `en` low) is seen in the same cycle that the counter sees it. The bench changes inputs only on falling edges and drives event strobes, writes and clear strobes one cycle wide. Some strobes are aimed deliberately at a running count, including non-selected events and repeat events, so that the ignore and cancel paths are exercised inside the assumed input envelope.

// File: rtl/dtt_pkg.sv
// Package: shared constants and types for the delayed transmit timer.
// Assumes an 8-bit register interface and a 14-bit delay length.
package dtt_pkg;
    localparam int          REG_W  = 8;
    localparam int          LEN_W  = 14;
    localparam int          N_EVT  = 4;
    localparam logic [7:0]  HI_DEF = 8'hC2;
    localparam logic [7:0]  LO_DEF = 8'h00;

    // Start selector encoding; value equals the event index it picks.
    typedef enum logic [1:0] {
        START_TXSOF_BEGIN = 2'b00,
        START_TXSOF_END   = 2'b01,
        START_RXSOF_BEGIN = 2'b10,
        START_RXSOF_END   = 2'b11
    } start_sel_e;

    typedef struct packed {
        start_sel_e        sel;
        logic [LEN_W-1:0]  len;
    } tmr_cfg_t;
endpackage

// File: rtl/dtt_regs.sv
// Module: control register pair with readback.
// Holds the high byte (selector + length[13:8]) and low byte (length[7:0]).
// Assumes synchronous active-low reset; enable low and clear strobe force defaults.
module dtt_regs
    import dtt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mode_clr,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output tmr_cfg_t         cfg
);
    logic [REG_W-1:0] hi_q;
    logic [REG_W-1:0] lo_q;

    // Register update: defaults win over writes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || mode_clr) begin
            hi_q <= HI_DEF;
            lo_q <= LO_DEF;
        end else if (wr_en) begin
            if (wr_sel) lo_q <= wr_data;
            else        hi_q <= wr_data;
        end
    end

    // Readback mux returns stored bytes only.
    always_comb begin
        rd_data = rd_sel ? lo_q : hi_q;
    end

    // Field extraction for the counter.
    always_comb begin
        cfg.sel = start_sel_e'(hi_q[7:6]);
        cfg.len = {hi_q[5:0], lo_q};
    end

    // R3: a clear strobe leaves both registers at defaults.
    assert_clr_defaults_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_clr |=> (hi_q == HI_DEF && lo_q == LO_DEF));

    // R1: enable low leaves both registers at defaults.
    assert_en_low_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (hi_q == HI_DEF && lo_q == LO_DEF));
endmodule

// File: rtl/dtt_event_sel.sv
// Module: picks the arming strobe named by the start selector.
// Assumes strobes are synchronous to clk.
module dtt_event_sel
    import dtt_pkg::*;
(
    input  start_sel_e       sel,
    input  logic [N_EVT-1:0] evts,
    output logic             hit
);
    logic [N_EVT-1:0] sel_oh;

    // One-hot decode of the selector, one gate per event.
    for (genvar gi = 0; gi < N_EVT; gi++) begin : g_dec
        assign sel_oh[gi] = (sel == start_sel_e'(gi)) && evts[gi];
    end

    // Any masked strobe arms.
    always_comb begin
        hit = |sel_oh;
    end
endmodule

// File: rtl/dtt_prescaler.sv
// Module: divides clk into one step tick per STEP_CYCLES cycles.
// Restarts on arm so the first step is full; runs only while the count is live.
module dtt_prescaler #(
    parameter int STEP_CYCLES = 118
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int PS_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(STEP_CYCLES - 1);

    logic [PS_W-1:0] ps_q;

    // Step phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) ps_q <= '0;
        else if (ps_q == PS_LAST)      ps_q <= '0;
        else                           ps_q <= ps_q + 1'b1;
    end

    // Tick on the last phase of each step.
    always_comb begin
        tick = run && (ps_q == PS_LAST);
    end

    // R5: the phase never leaves its step window.
    assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ps_q <= PS_LAST);
endmodule

// File: rtl/dtt_counter.sv
// Module: one-shot step counter producing the transmit-start pulse.
// Assumes arm is only raised with a non-zero length and never with abort.
module dtt_counter
    import dtt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             abort,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             tx_start
);
    logic [LEN_W-1:0] cnt_q;
    logic             last_step;

    // Final step detect.
    always_comb begin
        last_step = tick && (cnt_q == LEN_W'(1));
    end

    // Count state: arm, decrement, finish or cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt_q    <= '0;
            tx_start <= 1'b0;
        end else begin
            tx_start <= 1'b0;
            if (busy) begin
                if (abort) begin
                    busy  <= 1'b0;
                    cnt_q <= '0;
                end else if (last_step) begin
                    busy     <= 1'b0;
                    cnt_q    <= '0;
                    tx_start <= 1'b1;
                end else if (tick) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (arm) begin
                busy  <= 1'b1;
                cnt_q <= len;
            end
        end
    end

    // R6: arming never happens with a zero length.
    assert_no_zero_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> (len != '0));

    // R5: the pulse lasts one cycle.
    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R5: the pulse comes only as a running count ends.
    assert_pulse_ends_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (!busy && $past(busy)));

    // R7: a live count keeps running until its last step.
    assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !abort && !last_step) |=> busy);

    // R8: a cancel ends the count with no pulse.
    assert_abort_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (!busy && !tx_start));
endmodule

// File: rtl/dly_tx_timer.sv
// Module: top of the event-triggered delayed transmit timer.
// Joins register file, event select, prescaler and counter. Assumes all
// inputs synchronous to clk and a synchronous active-low reset.
module dly_tx_timer
    import dtt_pkg::*;
#(
    parameter int STEP_CYCLES = 118
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       mode_clr,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       rd_sel,
    output logic [7:0] rd_data,
    input  logic       ev_txsof_begin,
    input  logic       ev_txsof_end,
    input  logic       ev_rxsof_begin,
    input  logic       ev_rxsof_end,
    output logic       tx_start,
    output logic       busy
);
    tmr_cfg_t         cfg;
    logic [N_EVT-1:0] evts;
    logic             evt_hit;
    logic             abort;
    logic             arm;
    logic             tick;

    // Event vector, index equals selector code.
    always_comb begin
        evts = {ev_rxsof_end, ev_rxsof_begin, ev_txsof_end, ev_txsof_begin};
    end

    // Cancel causes and arming qualification.
    always_comb begin
        abort = wr_en || mode_clr || !en;
        arm   = !busy && evt_hit && !abort && (cfg.len != '0);
    end

    dtt_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mode_clr (mode_clr),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .cfg      (cfg)
    );

    dtt_event_sel u_evsel (
        .sel  (cfg.sel),
        .evts (evts),
        .hit  (evt_hit)
    );

    dtt_prescaler #(.STEP_CYCLES(STEP_CYCLES)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (arm),
        .run     (busy),
        .tick    (tick)
    );

    dtt_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .abort    (abort),
        .tick     (tick),
        .len      (cfg.len),
        .busy     (busy),
        .tx_start (tx_start)
    );
endmodule

// File: tb/tb_dly_tx_timer.sv
// Bench: behavioural cycle model compared with the design every clock,
// plus directed scenario checks on pulse counts and readback.
module tb_dly_tx_timer;
    localparam int STEP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       mode_clr = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b0;
    logic [3:0] ev = 4'h0;
    logic [7:0] rd_data;
    logic       tx_start;
    logic       busy;

    int n_run = 0;
    int n_fail = 0;
    int pulses = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    dly_tx_timer #(.STEP_CYCLES(STEP)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_clr(mode_clr),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .ev_txsof_begin(ev[0]), .ev_txsof_end(ev[1]),
        .ev_rxsof_begin(ev[2]), .ev_rxsof_end(ev[3]),
        .tx_start(tx_start), .busy(busy)
    );

    // Behavioural reference: remaining cycles until the pulse.
    logic [7:0] m_hi, m_lo;
    logic       m_busy, m_pulse;
    int         m_rem;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi <= 8'hC2; m_lo <= 8'h00; m_busy <= 1'b0; m_pulse <= 1'b0; m_rem <= 0;
        end else begin
            int  len;
            bit  cancel;
            len    = {m_hi[5:0], m_lo};
            cancel = wr_en || mode_clr || !en;
            m_pulse <= 1'b0;
            if (m_busy) begin
                if (cancel) m_busy <= 1'b0;
                else if (m_rem == 1) begin m_busy <= 1'b0; m_pulse <= 1'b1; end
                else m_rem <= m_rem - 1;
            end else if (!cancel && ev[m_hi[7:6]] && len != 0) begin
                m_busy <= 1'b1;
                m_rem  <= len * STEP;
            end
            if (!en || mode_clr) begin m_hi <= 8'hC2; m_lo <= 8'h00; end
            else if (wr_en) begin
                if (wr_sel) m_lo <= wr_data; else m_hi <= wr_data;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp_v, $time);
        end
    endtask

    // Per-clock comparison, away from the rising edge.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            check(tx_start === m_pulse, {cur_req, " R5 tx_start"}, tx_start, m_pulse);
            check(busy === m_busy, {cur_req, " busy"}, busy, m_busy);
            check(rd_data === (rd_sel ? m_lo : m_hi), {cur_req, " R2 readback"},
                  rd_data, rd_sel ? m_lo : m_hi);
            if (tx_start === 1'b1) pulses++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic fire(input int idx);
        ev[idx] = 1'b1;
        cyc(1);
        ev = 4'h0;
    endtask

    task automatic read_chk(input bit sel, input logic [7:0] exp_v, input string req);
        rd_sel = sel;
        #1;
        check(rd_data === exp_v, req, rd_data, exp_v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int p0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset defaults
        cur_req = "R1";
        read_chk(1'b0, 8'hC2, "R1 high default");
        read_chk(1'b1, 8'h00, "R1 low default");
        // R2 write and readback
        cur_req = "R2";
        wr(1'b0, 8'h15); wr(1'b1, 8'hA7);
        read_chk(1'b0, 8'h15, "R2 high readback");
        read_chk(1'b1, 8'hA7, "R2 low readback");
        // R1 enable low forces defaults
        en = 1'b0; cyc(1); en = 1'b1;
        read_chk(1'b0, 8'hC2, "R1 en low high");
        read_chk(1'b1, 8'h00, "R1 en low low");
        // R4 / R5 each selector, wrong events first
        cur_req = "R4";
        for (int s = 0; s < 4; s++) begin
            wr(1'b0, 8'(s << 6)); wr(1'b1, 8'd5);
            p0 = pulses;
            fire((s + 1) % 4); fire((s + 2) % 4); fire((s + 3) % 4);
            cyc(5 * STEP + 4);
            check(pulses == p0, "R4 other event armed", pulses - p0, 0);
            fire(s);
            cyc(5 * STEP + 4);
            check(pulses == p0 + 1, "R4 selected event pulse", pulses - p0, 1);
        end
        // R5 shortest length
        cur_req = "R5";
        wr(1'b0, 8'h40); wr(1'b1, 8'h01);
        p0 = pulses; fire(1); cyc(STEP + 3);
        check(pulses == p0 + 1, "R5 length one", pulses - p0, 1);
        // R6 zero length
        cur_req = "R6";
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
        p0 = pulses;
        for (int i = 0; i < 4; i++) fire(i);
        cyc(20);
        check(pulses == p0 && busy == 1'b0, "R6 zero length idle", pulses - p0, 0);
        // R7 repeat events while busy
        cur_req = "R7";
        wr(1'b1, 8'd10);
        p0 = pulses; fire(0); cyc(7); fire(0); cyc(5); fire(0);
        cyc(10 * STEP + 4);
        check(pulses == p0 + 1, "R7 single pulse", pulses - p0, 1);
        // R8 cancel by write, clear and enable low; R3 clear reloads
        cur_req = "R8";
        p0 = pulses; fire(0); cyc(6); wr(1'b1, 8'd10); cyc(12 * STEP);
        check(pulses == p0, "R8 write cancel", pulses - p0, 0);
        fire(0); cyc(6); mode_clr = 1'b1; wr(1'b1, 8'h33); mode_clr = 1'b0; cyc(12 * STEP);
        check(pulses == p0, "R8 clear cancel", pulses - p0, 0);
        cur_req = "R3";
        read_chk(1'b0, 8'hC2, "R3 clear high");
        read_chk(1'b1, 8'h00, "R3 clear low");
        cur_req = "R8";
        wr(1'b0, 8'h00); wr(1'b1, 8'd10);
        fire(0); cyc(6); en = 1'b0; cyc(1); en = 1'b1; cyc(12 * STEP);
        check(pulses == p0, "R8 enable cancel", pulses - p0, 0);
        // R5 default configuration: rx end, length 512
        cur_req = "R5";
        p0 = pulses; fire(3); cyc(512 * STEP + 4);
        check(pulses == p0 + 1, "R5 default config", pulses - p0, 1);
        // R5 longest length
        wr(1'b0, 8'h3F); wr(1'b1, 8'hFF);
        p0 = pulses; fire(0); cyc(16383 * STEP + 4);
        check(pulses == p0 + 1, "R5 max length", pulses - p0, 1);
        cyc(2);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule